// File: doc/BRIEF.md
# Exception Return Status Restorer

This block works out the processor status word that takes effect when an exception-return instruction completes. It takes the status word now in force, the status word saved at exception entry, two instruction-block-disable controls and three configuration flags. A single combinational path checks whether the return is permitted. It cleans the saved conditional-block (IT) state. It then builds the next status word from the fields that suit the execution width of the result. On the clock edge where the return strobe is high, that word is loaded into the status register.

The block uses a status-word layout of its own. Bits 4:0 hold the mode. Bit 4 set means 32-bit state, and bits 3:0 then carry a 32-bit mode code. Bit 4 clear means 64-bit state, with bits 3:2 giving the exception level (0..3), bit 1 reserved as zero and bit 0 the stack select. The remaining fields sit at these positions: T bit 5, F bit 6, I bit 7, A bit 8, E bit 9, IT[7:2] in bits 15:10, GE in bits 19:16, illegal-state (IL) bit 20, single-step (SS) bit 21, D bit 22, IT[1:0] in bits 26:25, Q bit 27, V bit 28, C bit 29, Z bit 30 and N bit 31. Bits 24:23 are never set.

The valid 32-bit mode codes and their exception levels are: 0x0→EL0, 0x1, 0x2, 0x3, 0x7, 0xB and 0xF→EL1, 0xA→EL2 and 0x6→EL3. Every other code is invalid.

Top module: `esr_restorer`

## Requirements
- R1: While `rst` is high at a clock edge, `status_q` becomes all zeros.
- R2: `status_q` keeps its value on every edge where `ret_strobe` is low, whatever the other inputs do.
- R3: A return is illegal if the saved mode is an invalid 32-bit code, or if its target level is above the level of the current word. On an illegal return, bit 20 of the result is 1 and bits 4:0 are copied from the current word.
- R4: A return is illegal if it targets EL3 while `has_secure` is 0, or if it targets EL2 while `has_virt` is 0.
- R5: A return to 64-bit state is illegal if `top_is_64` is 0, if saved bit 1 is set, or if it targets EL0 with saved bit 0 set.
- R6: On a legal return, bits 4:0 come from the saved word and bit 20 is copied from saved bit 20.
- R7: Bit 21 (SS) of the result is always 0.
- R8: Bits 31:28 always come from the saved word. If the result is 32-bit (bit 4 = 1), Q, GE, E, A, I, F and T are also copied. If it is 64-bit, D, A, I and F are copied. All other bits are 0, apart from the mode, IL and IT fields.
- R9: The restored IT value is 0 if saved T is 0, if saved IL is 1, or if IT[7:4] is nonzero while IT[3:0] is zero.
- R10: The restored IT value is also 0 if IT[2:0] is nonzero and the selected disable control is 1. `hyp_itblk_dis` is selected when the target level is EL2, and `oth_itblk_dis` is selected for any other target level.
- R11: In a 32-bit result, IT[7:2] lands in bits 15:10 and IT[1:0] in bits 26:25. Both fields are 0 in a 64-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ret_strobe | input | 1 | Load the computed word this cycle |
| cur_word | input | 32 | Status word in force now |
| saved_word | input | 32 | Status word saved at exception entry |
| hyp_itblk_dis | input | 1 | IT-block disable for EL2 targets |
| oth_itblk_dis | input | 1 | IT-block disable for other targets |
| has_secure | input | 1 | EL3 is implemented |
| has_virt | input | 1 | EL2 is implemented |
| top_is_64 | input | 1 | Highest level runs 64-bit |
| status_q | output | 32 | Registered status word |

## Verification
The checker watches several behaviours on every edge. The register holds when no strobe is present, and SS stays clear. The flag nibble follows the saved word. A 64-bit return with the reserved bit set, or to a missing EL3, is marked illegal and keeps the current mode. A saved T of 0 empties both IT fields. Other behaviours need the bench's vectors, because their expected values depend on the whole field set: the legality order across levels, the choice between the two disable controls, the reserved-IT rule, the split IT placement and the masks that differ by width.

// File: rtl/esr_pkg.sv
package esr_pkg;
    localparam int WORD_W = 32;
    localparam int MODE_W = 5;
    localparam int EL_W   = 2;
    localparam int IT_W   = 8;

    localparam int B_T    = 5;
    localparam int B_IL   = 20;
    localparam int B_SS   = 21;
    localparam int IT_HI_LSB = 10;
    localparam int IT_LO_LSB = 25;

    localparam logic [WORD_W-1:0] KEEP_NARROW = 32'hF80F_03E0;
    localparam logic [WORD_W-1:0] KEEP_WIDE   = 32'hF040_01C0;

    typedef logic [EL_W-1:0] el_t;

    typedef struct packed {
        logic valid;
        logic narrow;
        el_t  lvl;
    } mode_info_t;
endpackage

// File: rtl/esr_mode_decode.sv
module esr_mode_decode
    import esr_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_info_t        info
);
    function automatic mode_info_t narrow_lookup(input logic [3:0] code);
        mode_info_t r;
        r.narrow = 1'b1;
        r.valid  = 1'b1;
        unique case (code)
            4'h0:                      r.lvl = 2'd0;
            4'h1, 4'h2, 4'h3, 4'h7,
            4'hB, 4'hF:                r.lvl = 2'd1;
            4'hA:                      r.lvl = 2'd2;
            4'h6:                      r.lvl = 2'd3;
            default: begin
                r.valid = 1'b0;
                r.lvl   = 2'd0;
            end
        endcase
        return r;
    endfunction

    always_comb begin
        if (mode[MODE_W-1]) begin
            info = narrow_lookup(mode[3:0]);
        end else begin
            info.valid  = 1'b1;
            info.narrow = 1'b0;
            info.lvl    = mode[3:2];
        end
    end
endmodule

// File: rtl/esr_legality.sv
module esr_legality
    import esr_pkg::*;
(
    input  mode_info_t        tgt,
    input  mode_info_t        now,
    input  logic [1:0]        wide_low,
    input  logic              has_secure,
    input  logic              has_virt,
    input  logic              top_is_64,
    output logic              illegal
);
    logic bad_level;
    logic bad_impl;
    logic bad_wide;

    always_comb begin
        bad_level = !tgt.valid || (tgt.lvl > now.lvl);
        bad_impl  = ((tgt.lvl == 2'd3) && !has_secure) ||
                    ((tgt.lvl == 2'd2) && !has_virt);
        bad_wide  = !tgt.narrow &&
                    (!top_is_64 || wide_low[1] ||
                     ((tgt.lvl == 2'd0) && wide_low[0]));
        illegal   = bad_level || bad_impl || bad_wide;
    end
endmodule

// File: rtl/esr_it_restore.sv
module esr_it_restore
    import esr_pkg::*;
(
    input  logic [IT_W-1:0] it_saved,
    input  logic            t_saved,
    input  logic            il_saved,
    input  el_t             tgt_lvl,
    input  logic            hyp_dis,
    input  logic            oth_dis,
    output logic [IT_W-1:0] it_out
);
    logic reserved;
    logic dis_sel;

    always_comb begin
        reserved = (it_saved[7:4] != 4'd0) && (it_saved[3:0] == 4'd0);
        dis_sel  = (tgt_lvl == 2'd2) ? hyp_dis : oth_dis;
        if (!t_saved || il_saved || reserved)
            it_out = '0;
        else if (dis_sel && (it_saved[2:0] != 3'd0))
            it_out = '0;
        else
            it_out = it_saved;
    end
endmodule

// File: rtl/esr_restorer.sv
module esr_restorer
    import esr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ret_strobe,
    input  logic [31:0]       cur_word,
    input  logic [31:0]       saved_word,
    input  logic              hyp_itblk_dis,
    input  logic              oth_itblk_dis,
    input  logic              has_secure,
    input  logic              has_virt,
    input  logic              top_is_64,
    output logic [31:0]       status_q
);
    localparam int NSRC = 2;

    logic [MODE_W-1:0] mode_src [NSRC];
    mode_info_t        info     [NSRC];

    assign mode_src[0] = saved_word[MODE_W-1:0];
    assign mode_src[1] = cur_word[MODE_W-1:0];

    for (genvar g = 0; g < NSRC; g++) begin : g_dec
        esr_mode_decode u_dec (.mode(mode_src[g]), .info(info[g]));
    end

    logic unused_cur_hi;
    assign unused_cur_hi = ^cur_word[WORD_W-1:MODE_W];

    logic illegal;
    esr_legality u_leg (
        .tgt(info[0]), .now(info[1]), .wide_low(saved_word[1:0]),
        .has_secure(has_secure), .has_virt(has_virt),
        .top_is_64(top_is_64), .illegal(illegal)
    );

    logic [IT_W-1:0] it_in, it_new;
    assign it_in = {saved_word[IT_HI_LSB +: 6], saved_word[IT_LO_LSB +: 2]};

    esr_it_restore u_it (
        .it_saved(it_in), .t_saved(saved_word[B_T]),
        .il_saved(saved_word[B_IL]), .tgt_lvl(info[0].lvl),
        .hyp_dis(hyp_itblk_dis), .oth_dis(oth_itblk_dis), .it_out(it_new)
    );

    logic [WORD_W-1:0] next_word;
    logic [MODE_W-1:0] mode_out;
    logic              out_narrow;

    always_comb begin
        mode_out   = illegal ? cur_word[MODE_W-1:0] : saved_word[MODE_W-1:0];
        out_narrow = mode_out[MODE_W-1];
        next_word  = saved_word & (out_narrow ? KEEP_NARROW : KEEP_WIDE);
        if (out_narrow) begin
            next_word[IT_HI_LSB +: 6] = it_new[7:2];
            next_word[IT_LO_LSB +: 2] = it_new[1:0];
        end
        next_word[MODE_W-1:0] = mode_out;
        next_word[B_IL]       = illegal | saved_word[B_IL];
        next_word[B_SS]       = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            status_q <= '0;
        else if (ret_strobe)
            status_q <= next_word;
    end
endmodule

// File: rtl/esr_restorer_chk.sv
module esr_restorer_chk (
    input logic        clk,
    input logic        rst,
    input logic        ret_strobe,
    input logic [31:0] cur_word,
    input logic [31:0] saved_word,
    input logic        has_secure,
    input logic [31:0] status_q
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (status_q == 32'd0));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !ret_strobe |=> $stable(status_q));

    p_ss_zero_r7: assert property (@(posedge clk) disable iff (rst)
        status_q[21] == 1'b0);

    p_flags_r8: assert property (@(posedge clk) disable iff (rst)
        ret_strobe |=> (status_q[31:28] == $past(saved_word[31:28])));

    p_reserved_bit_r5: assert property (@(posedge clk) disable iff (rst)
        (ret_strobe && !saved_word[4] && saved_word[1])
        |=> (status_q[20] && (status_q[4:0] == $past(cur_word[4:0]))));

    p_no_secure_r4: assert property (@(posedge clk) disable iff (rst)
        (ret_strobe && !saved_word[4] && (saved_word[3:2] == 2'b11) && !has_secure)
        |=> status_q[20]);

    p_t_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (ret_strobe && !saved_word[5])
        |=> ((status_q[15:10] == 6'd0) && (status_q[26:25] == 2'd0)));
endmodule

bind esr_restorer esr_restorer_chk u_chk (
    .clk(clk), .rst(rst), .ret_strobe(ret_strobe), .cur_word(cur_word),
    .saved_word(saved_word), .has_secure(has_secure), .status_q(status_q)
);

// File: tb/sim_esr_restorer.sv
`timescale 1ns/1ps
module sim_esr_restorer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ret_strobe = 1'b0;
    logic [31:0] cur_word = '0;
    logic [31:0] saved_word = '0;
    logic        hyp_itblk_dis = 1'b0;
    logic        oth_itblk_dis = 1'b0;
    logic        has_secure = 1'b1;
    logic        has_virt = 1'b1;
    logic        top_is_64 = 1'b1;
    logic [31:0] status_q;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    esr_restorer u0 (
        .clk(clk), .rst(rst), .ret_strobe(ret_strobe), .cur_word(cur_word),
        .saved_word(saved_word), .hyp_itblk_dis(hyp_itblk_dis),
        .oth_itblk_dis(oth_itblk_dis), .has_secure(has_secure),
        .has_virt(has_virt), .top_is_64(top_is_64), .status_q(status_q)
    );

    localparam int NV = 19;
    // cfg bits: {hyp_dis, oth_dis, secure, virt, top64}
    localparam logic [31:0] V_CUR [NV] = '{
        32'h0D, 32'h0D, 32'h0D, 32'h0D, 32'h05, 32'h0D, 32'h0D, 32'h0D,
        32'h0D, 32'h0D, 32'h0D, 32'h0D, 32'h0D, 32'h0D, 32'h0D, 32'h0D,
        32'h0D, 32'h0D, 32'h10};
    localparam logic [31:0] V_SAV [NV] = '{
        32'hF000_0004, 32'h8860_01C8, 32'h4000_0008, 32'h0000_000C,
        32'h0000_000C, 32'h0000_0006, 32'h0000_0001, 32'h0000_0004,
        32'h0010_0004, 32'h084A_0A33, 32'h0000_0C33, 32'h0000_0C33,
        32'h0200_043A, 32'h0200_043A, 32'h0000_1033, 32'h0000_0813,
        32'h0010_0833, 32'h2000_0014, 32'h0000_0833};
    localparam logic [4:0] V_CFG [NV] = '{
        5'b00111, 5'b00111, 5'b00101, 5'b00011, 5'b00111, 5'b00111,
        5'b00111, 5'b00110, 5'b00111, 5'b00111, 5'b01111, 5'b10111,
        5'b10111, 5'b01111, 5'b00111, 5'b00111, 5'b00111, 5'b00111,
        5'b00111};
    localparam logic [31:0] V_EXP [NV] = '{
        32'hF000_0004, 32'h8040_01C8, 32'h4010_000D, 32'h0010_000D,
        32'h0010_0005, 32'h0010_000D, 32'h0010_000D, 32'h0010_000D,
        32'h0010_0004, 32'h080A_0A33, 32'h0000_0033, 32'h0000_0C33,
        32'h0000_003A, 32'h0200_043A, 32'h0000_0033, 32'h0000_0013,
        32'h0010_0033, 32'h2010_000D, 32'h0010_0830};

    function automatic string vec_req(input int i);
        case (i)
            0, 8:          return "R6";
            1:             return "R8/R7";
            2, 3:          return "R4";
            4, 17, 18:     return "R3";
            5, 6, 7:       return "R5";
            9, 13:         return "R11";
            10, 11, 12:    return "R10";
            default:       return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] c, input logic [31:0] s,
                         input logic [4:0] cfg, input logic strobe);
        @(negedge clk);
        cur_word = c;
        saved_word = s;
        {hyp_itblk_dis, oth_itblk_dis, has_secure, has_virt, top_is_64} = cfg;
        ret_strobe = strobe;
        @(negedge clk);
        ret_strobe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", status_q, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(V_CUR[i], V_SAV[i], V_CFG[i], 1'b1);
            check(vec_req(i), status_q, V_EXP[i]);
        end

        // R2: new inputs with no strobe leave the register alone
        apply(32'h0D, 32'hF000_0004, 5'b00111, 1'b1);
        apply(32'h0D, 32'h0000_0013, 5'b11000, 1'b0);
        check("R2", status_q, 32'hF000_0004);
        apply(32'h05, 32'h4000_000C, 5'b00000, 1'b0);
        check("R2", status_q, 32'hF000_0004);

        // R7: SS set in the saved word never reaches the result
        apply(32'h0D, 32'h0020_0004, 5'b00111, 1'b1);
        check("R7", status_q, 32'h0000_0004);

        // R1: reset in mid run clears the register
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", status_q, 32'h0);
        rst = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule